// File: doc/BRIEF.md
# Serial Register-File Slave

This block is a two-wire serial slave (SMBus/I2C framing) that gives an external host access to a small bank of 8-bit control registers. The chip's core reads those registers as one parallel bus. SCL and SDA are oversampled by the local clock. The slave pulls SDA low through a single open-drain enable, and never drives it high. The slave does not stretch the clock and has no bus timeout.

The first byte after the address is a command byte. When its top bit is set, the access is a single-byte access, and the low seven bits select the register. When its top bit is clear, the access is a counted block transfer that always starts at register 0, whatever the low seven bits hold. A block write carries a byte count ahead of its data. A block read returns a byte count ahead of its data. Register 7 is a fixed identification byte. The low strap bits of register 0 show the latched frequency-select inputs. Neither of these can be written.

The parallel register outputs are plain level signals with no handshake: each one changes one clock after the write strobe that updates it.

Top module: `smb_regfile_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69 (0xD2 with the write bit, 0xD3 with the read bit). For any other address it leaves SDA undriven for the rest of that transfer and changes no register. All bits on the wire are most significant first.
- R2: A command byte with bit 7 set and a data byte write that byte to the register at offset cmd[6:0]. Every byte is acknowledged. The register output updates with the new value.
- R3: A command byte with bit 7 set, followed by a repeated start and the read address, returns the register at offset cmd[6:0]. The master ends the read with a not-acknowledge, after which the slave releases SDA.
- R4: A command byte with bit 7 clear starts a block write at register 0, even when cmd[6:0] is non-zero. A byte count follows, and the data bytes then go to registers 0, 1, 2 and upward. Every byte is acknowledged.
- R5: A block read (command 0x00, repeated start, read address) first returns a count byte equal to the number of registers (0x0F). It then returns registers 0, 1, 2 and upward until the master sends a not-acknowledge.
- R6: Data bytes of a block write beyond its byte count are acknowledged but not stored.
- R7: After reset, the registers read as follows. Register 0 = 0x40 with the straps in bits 4:0. Register 1 = 0x7F. Register 3 = 0xFF. Register 5 = 0xDF. Register 6 = 0x03. Register 7 = 0x48. Register 8 = 0x60. Register 14 = 0x40. Every other register = 0x00. SDA is released.
- R8: Register 7 always reads 0x48, and writes to it are ignored. Bits 4:0 of register 0 always follow the strap input, and writes to those bits are ignored. Bits 7:5 of register 0 are writable.
- R9: Offsets 15 and above are acknowledged. Writes to them are discarded, and reads from them return 0x00.
- R10: A block write stopped after any whole data byte keeps the bytes already sent and leaves the rest of the registers unchanged. The next transfer works normally.
- R11: The slave changes its SDA drive only while SCL is low, and it releases SDA after a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| strap_fs | input | STRAP_W (5) | Latched frequency-select strap values |
| reg_q | output | NUM_REGS*8 (120) | Register contents, register k in bits 8k+7:8k |

## Verification
The SDA-timing check relies on each SCL low phase lasting longer than the synchronizer delay plus one clock. It also relies on the master never issuing start or stop while the slave holds SDA low. The bench keeps every SCL phase at eight clocks, and it issues stop and repeated start only after the slave has released the line. The write-path checks assume that a write strobe reflects one complete received byte. The stimulus therefore sends only whole bytes. It mixes seeded random byte writes, byte reads and block writes (counts and offsets drawn across and beyond the register range) with directed cases for the address mismatch, the read-only bits, over-long and early-stopped block writes, and reads past the last register.

// File: rtl/smb_rf_pkg.sv
package smb_rf_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_ACKHOLD, S_TX, S_MACK, S_LOAD
  } link_st_t;

  typedef enum logic [1:0] {
    P_ADDR, P_CMD, P_COUNT, P_DATA
  } phase_t;

  // reset value of each register
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h40;
      1:       return 8'h7F;
      3:       return 8'hFF;
      5:       return 8'hDF;
      6:       return 8'h03;
      7:       return 8'h48;
      8:       return 8'h60;
      14:      return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // bits that a host write may change
  function automatic logic [7:0] reg_wmask(input int idx, input int id_idx, input int strap_w);
    if (idx == id_idx) return 8'h00;
    if (idx == 0)      return 8'hFF << strap_w;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_in};
      sda_p <= {sda_p[STAGES-1:0], sda_in};
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_q     = scl_p[STAGES];
  assign sda_q     = sda_p[STAGES];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_link_ctrl.sv
module smb_link_ctrl import smb_rf_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 15,
  parameter int         PTR_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  link_st_t         st;
  phase_t           ph;
  logic [3:0]       bcnt;
  logic [7:0]       sh;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       remain;
  logic             byte_mode, tx_mode, send_cnt;
  logic [7:0]       rx_byte, tx_byte;

  assign rx_byte = {sh[6:0], sda_s};
  assign rd_addr = ptr;

  always_comb tx_byte = send_cnt ? CNT_BYTE : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ph <= P_ADDR;  bcnt <= '0;  sh <= '0;
      ptr <= '0;  remain <= '0;  byte_mode <= 1'b0;
      tx_mode <= 1'b0;  send_cnt <= 1'b0;  sda_oe <= 1'b0;
      wr_en <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= S_RX;
        ph     <= P_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sh   <= rx_byte;
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              st <= S_ACK;
              case (ph)
                P_ADDR: begin
                  if (rx_byte[7:1] == DEV_ADDR) begin
                    tx_mode  <= rx_byte[0];
                    send_cnt <= rx_byte[0] & ~byte_mode;
                    ph       <= P_CMD;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                P_CMD: begin
                  byte_mode <= rx_byte[7];
                  ptr       <= rx_byte[7] ? rx_byte[6:0] : '0;
                  remain    <= 8'd1;
                  ph        <= rx_byte[7] ? P_DATA : P_COUNT;
                end
                P_COUNT: begin
                  remain <= rx_byte;
                  ph     <= P_DATA;
                end
                default: begin
                  if (remain != 8'd0) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= rx_byte;
                    ptr     <= ptr + PTR_W'(1);
                    remain  <= remain - 8'd1;
                  end
                end
              endcase
            end
          end
          S_ACK: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_ACKHOLD;
          end
          S_ACKHOLD, S_LOAD: if (scl_fall) begin
            if (tx_mode) begin
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              st     <= S_TX;
              bcnt   <= '0;
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr <= ptr + PTR_W'(1);
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
              bcnt   <= '0;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_MACK: if (scl_rise) st <= sda_s ? S_IDLE : S_LOAD;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank import smb_rf_pkg::*; #(
  parameter int         NUM_REGS = 15,
  parameter int         STRAP_W  = 5,
  parameter int         ID_IDX   = 7,
  parameter logic [7:0] ID_BYTE  = 8'h48,
  parameter int         PTR_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_addr,
  input  logic [STRAP_W-1:0]    strap,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] reg_q
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [7:0] view [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [7:0] WM  = reg_wmask(k, ID_IDX, STRAP_W);
    localparam logic [7:0] DEF = reg_default(k);
    logic [7:0] ro_val, stor;

    if (k == ID_IDX) begin : g_id
      assign ro_val = ID_BYTE;
    end else if (k == 0) begin : g_strap
      assign ro_val = 8'(strap);
    end else begin : g_none
      assign ro_val = 8'h00;
    end

    if (WM != 8'h00) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stor <= DEF & WM;
        else if (wr_en && wr_addr == PTR_W'(k))
          stor <= wr_data & WM;
      end
    end else begin : g_ro
      assign stor = 8'h00;
    end

    assign view[k]           = (stor & WM) | (ro_val & ~WM);
    assign reg_q[k*8 +: 8]   = view[k];
  end

  always_comb begin
    if (int'(rd_addr) < NUM_REGS) rd_data = view[rd_addr[IDX_W-1:0]];
    else                          rd_data = 8'h00;
  end
endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave #(
  parameter int         NUM_REGS    = 15,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         ID_IDX      = 7,
  parameter logic [7:0] ID_BYTE     = 8'h48,
  parameter int         STRAP_W     = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  input  logic [STRAP_W-1:0]    strap_fs,
  output logic [NUM_REGS*8-1:0] reg_q
);
  localparam int PTR_W = 7;

  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0]       wr_data, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_link_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W), .ID_IDX(ID_IDX),
                 .ID_BYTE(ID_BYTE), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .strap(strap_fs),
    .rd_data(rd_data), .reg_q(reg_q)
  );

  wire unused_ok = &{1'b0, scl_s};
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk import smb_rf_pkg::*; #(
  parameter int         NUM_REGS = 15,
  parameter int         ID_IDX   = 7,
  parameter logic [7:0] ID_BYTE  = 8'h48,
  parameter int         STRAP_W  = 5,
  parameter int         PTR_W    = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_in,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] reg_q,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_addr,
  input logic [7:0]            wr_data,
  input logic                  stop_det
);
  function automatic logic [NUM_REGS*8-1:0] rw_all();
    logic [NUM_REGS*8-1:0] m;
    for (int k = 0; k < NUM_REGS; k++) m[k*8 +: 8] = reg_wmask(k, ID_IDX, STRAP_W);
    return m;
  endfunction
  localparam logic [NUM_REGS*8-1:0] RW_ALL = rw_all();

  logic armed = 1'b0;
  always @(posedge clk) armed <= 1'b1;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_rst
    localparam logic [7:0] WM  = reg_wmask(k, ID_IDX, STRAP_W);
    localparam logic [7:0] DEF = reg_default(k);
    always @(negedge clk)
      if (armed && !rst_n)
        assert_reset_defaults_R7: assert ((reg_q[k*8 +: 8] & WM) == (DEF & WM))
          else $error("reset value wrong in register %0d", k);
  end

  always @(negedge clk)
    if (armed && !rst_n)
      assert_reset_release_R7: assert (!sda_oe) else $error("SDA driven in reset");

  // R2: storage changes only through a write strobe
  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q & RW_ALL));

  // R9: strobes past the last register leave storage untouched
  assert_oob_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(reg_q & RW_ALL));

  // R2 / R8: an in-range strobe lands in its register, masked to writable bits
  logic             p_en;
  logic [PTR_W-1:0] p_addr;
  logic [7:0]       p_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_en <= 1'b0; p_addr <= '0; p_data <= '0;
    end else begin
      p_en <= wr_en; p_addr <= wr_addr; p_data <= wr_data;
    end
  end
  always @(posedge clk)
    if (rst_n && p_en && int'(p_addr) < NUM_REGS)
      assert_write_lands_R2: assert ((reg_q[int'(p_addr)*8 +: 8] & reg_wmask(int'(p_addr), ID_IDX, STRAP_W))
                                     == (p_data & reg_wmask(int'(p_addr), ID_IDX, STRAP_W)))
        else $error("write to register %0d not applied", p_addr);

  // R11: SDA released after stop, and drive changes only while SCL is low
  assert_release_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R8: identification byte never deviates
  assert_id_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[ID_IDX*8 +: 8] == ID_BYTE);
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(
  .NUM_REGS(NUM_REGS), .ID_IDX(ID_IDX), .ID_BYTE(ID_BYTE),
  .STRAP_W(STRAP_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .reg_q(reg_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .stop_det(stop_det)
);

// File: tb/smb_regfile_slave_tb.sv
module smb_regfile_slave_tb;
  localparam int N  = 15;
  localparam int H  = 8;
  localparam logic [7:0] AW = 8'hD2;
  localparam logic [7:0] AR = 8'hD3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [4:0] strap = 5'h13;
  logic sda_oe;
  logic [N*8-1:0] reg_q;
  wire sda_bus = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  logic [7:0] model [N];
  logic [7:0] rbuf [N+1];
  logic [7:0] wbuf [24];

  always #4 clk = ~clk;

  smb_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .strap_fs(strap), .reg_q(reg_q)
  );

  function automatic logic [7:0] wmask(int off);
    if (off == 7) return 8'h00;
    if (off == 0) return 8'hE0;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expect_rd(int off);
    if (off >= N) return 8'h00;
    if (off == 7) return 8'h48;
    if (off == 0) return (model[0] & 8'hE0) | {3'b000, strap};
    return model[off];
  endfunction

  task automatic model_wr(int off, logic [7:0] d);
    if (off < N) model[off] = (model[off] & ~wmask(off)) | (d & wmask(off));
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic wbit(logic b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic rbit(output logic v);
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2); v = sda_bus; tick(H/2); scl_m = 1'b0;
  endtask

  task automatic send(logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(v);
    ack = ~v;
  endtask

  task automatic recv(logic last, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin rbit(v); b[i] = v; end
    wbit(last);
  endtask

  task automatic byte_write(logic [7:0] aw, logic [6:0] off, logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send(aw, a0);
    if (!a0) begin bus_stop(); ok = 1'b0; return; end
    send({1'b1, off}, a1);
    send(d, a2);
    bus_stop();
    ok = a1 & a2;
    if (aw == AW) model_wr(int'(off), d);
  endtask

  task automatic byte_read(logic [6:0] off, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); send(AW, a0); send({1'b1, off}, a1);
    bus_start(); send(AR, a2);
    recv(1'b1, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  // sends count cnt and the first n entries of wbuf
  task automatic block_write(logic [6:0] cmd_lo, int cnt, int n, output logic ok);
    logic a;
    ok = 1'b1;
    bus_start();
    send(AW, a); ok &= a;
    send({1'b0, cmd_lo}, a); ok &= a;
    send(8'(cnt), a); ok &= a;
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], a); ok &= a;
      if (i < cnt) model_wr(i, wbuf[i]);
    end
    bus_stop();
  endtask

  // rbuf[0] = count, rbuf[1..N] = registers
  task automatic block_read(output logic ok);
    logic a0, a1, a2;
    bus_start(); send(AW, a0); send(8'h00, a1);
    bus_start(); send(AR, a2);
    for (int i = 0; i <= N; i++) recv(i == N, rbuf[i]);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic check_regs(string tag);
    for (int k = 0; k < N; k++) chk(tag, {24'h0, reg_q[k*8 +: 8]}, {24'h0, expect_rd(k)});
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic ok;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) model[k] = 8'h00;
    model[0] = 8'h40; model[1] = 8'h7F; model[3] = 8'hFF; model[5] = 8'hDF;
    model[6] = 8'h03; model[7] = 8'h48; model[8] = 8'h60; model[14] = 8'h40;

    tick(5);
    check_regs("R7 reset");
    chk("R7 sda released", {31'h0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    tick(4);

    // R5 / R7: block read of defaults
    block_read(ok);
    chk("R5 ack", {31'h0, ok}, 32'h1);
    chk("R5 count", {24'h0, rbuf[0]}, 32'h0F);
    for (int k = 0; k < N; k++) chk("R5 data", {24'h0, rbuf[k+1]}, {24'h0, expect_rd(k)});

    // R2 / R3: byte write then byte read
    byte_write(AW, 7'd3, 8'hA5, ok);
    chk("R2 ack", {31'h0, ok}, 32'h1);
    check_regs("R2 regs");
    byte_read(7'd3, d, ok);
    chk("R3 data", {24'h0, d}, 32'hA5);
    chk("R3 released", {31'h0, sda_oe}, 32'h0);

    // R1: foreign address
    byte_write(8'hD0, 7'd4, 8'h5A, ok);
    chk("R1 no ack", {31'h0, ok}, 32'h0);
    check_regs("R1 regs");

    // R4 / R8: block write with non-zero low command bits
    wbuf[0] = 8'hFF; wbuf[1] = 8'h12; wbuf[2] = 8'h34;
    block_write(7'h05, 3, 3, ok);
    chk("R4 ack", {31'h0, ok}, 32'h1);
    check_regs("R4 regs");

    // R6: more bytes than count
    wbuf[0] = 8'h20; wbuf[1] = 8'h66; wbuf[2] = 8'h77; wbuf[3] = 8'h88;
    block_write(7'h00, 2, 4, ok);
    chk("R6 ack", {31'h0, ok}, 32'h1);
    chk("R6 reg2 kept", {24'h0, reg_q[16 +: 8]}, 32'h34);
    check_regs("R6 regs");

    // R8: identification byte and straps
    byte_write(AW, 7'd7, 8'h00, ok);
    byte_read(7'd7, d, ok);
    chk("R8 id", {24'h0, d}, 32'h48);
    strap = 5'h0A;
    tick(2);
    byte_read(7'd0, d, ok);
    chk("R8 strap", {24'h0, d}, {24'h0, expect_rd(0)});
    byte_write(AW, 7'd0, 8'h1F, ok);
    chk("R8 strap bits", {24'h0, reg_q[7:0]}, {24'h0, expect_rd(0)});

    // R9: offsets past the end
    byte_write(AW, 7'h20, 8'hC3, ok);
    chk("R9 ack", {31'h0, ok}, 32'h1);
    byte_read(7'h20, d, ok);
    chk("R9 read zero", {24'h0, d}, 32'h00);
    check_regs("R9 regs");

    // R10: early stop
    wbuf[0] = 8'hA0; wbuf[1] = 8'hB1;
    block_write(7'h00, 5, 2, ok);
    check_regs("R10 regs");
    byte_read(7'd2, d, ok);
    chk("R10 next xfer", {24'h0, d}, {24'h0, expect_rd(2)});

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op = $urandom_range(0, 2);
      int off = $urandom_range(0, 18);
      if (op == 0) begin
        byte_write(AW, 7'(off), 8'($urandom), ok);
        chk("R2 rnd ack", {31'h0, ok}, 32'h1);
      end else if (op == 1) begin
        byte_read(7'(off), d, ok);
        chk("R3 rnd read", {24'h0, d}, {24'h0, expect_rd(off)});
      end else begin
        int cnt = $urandom_range(1, N);
        int n = $urandom_range(1, cnt + 2);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        block_write(7'h00, cnt, n, ok);
        chk("R4 rnd ack", {31'h0, ok}, 32'h1);
      end
      check_regs("R6 rnd regs");
    end

    block_read(ok);
    chk("R5 final count", {24'h0, rbuf[0]}, 32'h0F);
    for (int k = 0; k < N; k++) chk("R5 final", {24'h0, rbuf[k+1]}, {24'h0, expect_rd(k)});
    chk("R11 released", {31'h0, sda_oe}, 32'h0);

    summary();
  end
endmodule